// File: doc/BRIEF.md
# Gated-Window Frequency Meter

This block measures the rate of an unknown measured clock against a reference clock. Software programs the length of a measurement window, counted in reference-clock cycles, turns on the free-run count enable, and then sets the meter-enable bit. For exactly that many reference cycles the block holds a gate open. The measured-clock domain counts its own rising edges while it sees the gate open. When the gate closes, the count is handed back to the reference domain and latched into a result register, and a sticky valid flag is raised.

The gate crosses into the measured domain through a two-flop synchroniser. The finished count comes back through a toggle handshake whose edge is synchronised into the reference domain. The count register is stable before that edge arrives. If the measured clock delivers no handshake within a bounded number of reference cycles, the measurement completes with a zero result. A counter that would wrap stops at all ones instead. Software polls the valid flag and then reads the result. It ends the measurement by clearing the meter enable and then the free-run enable.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control word (address 0), the monitor word (address 1) and the result word (address 2) all read zero.
- R2: Address 0 holds the window length in bits 23:0 and the meter enable in bit 24. Address 1 holds the writable free-run enable in bit 8 and the read-only valid flag in bit 0. Address 2 holds the result in its low CNT_W bits. All other bits, and address 3, read zero.
- R3: A write that changes the meter enable from 0 to 1 starts a measurement. The gate stays open for exactly the programmed number of reference cycles. The result is the number of measured-clock rising edges in that window, within ±3 of window × f_meas / f_ref.
- R4: Valid rises once per measurement, when the result is captured. It then stays set, and the result stays unchanged, for as long as the meter enable remains set.
- R5: Clearing the meter enable clears valid on the next reference-clock edge.
- R6: With the free-run enable clear, a measurement completes with valid set and a result of zero.
- R7: If the measured clock is stopped, the measurement completes with result zero once TMO_CYC reference cycles have passed after the window closes.
- R8: A count that would exceed 2^CNT_W − 1 saturates at all ones.
- R9: A window length of zero completes on the reference edge after the start is seen, with result zero and valid set.
- R10: Writes to the result word, and to the valid bit of the monitor word, have no effect.
- R11: A later measurement, started by clearing and then setting the meter enable, uses its newly programmed window and replaces the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the registers and the window logic |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| meas_clk | input | 1 | Clock under measurement |
| meas_rst_n | input | 1 | Synchronous active-low reset, measured domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |

## Verification
A window counter in the wrong state gives a result scaled away from the expected ratio. Because the error grows with the window length, long and short windows are both exercised. A lost or stale handshake toggle shows at the ports in one of two ways: valid never rises within the poll budget, or the zero timeout result appears where a real count was due. Either is visible a few dozen reference cycles after the window closes. A valid flag that fails to clear, or a result that drifts while valid is held, is caught by the next monitor or result read, within one or two cycles of the cause.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
// Package: register addresses, bit positions and the reference-side
// state type shared by the frequency meter modules.
package fm_pkg;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MON  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RES  = 2'd2;
    localparam int FRCK_POS  = 8;
    localparam int VALID_POS = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_DONE   = 2'd3
    } fm_state_t;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a single-bit level.
// Assumes the input is held long enough to be sampled by the destination clock.
module fm_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    // Sample the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            q      <= 1'b0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fm_meas_count.sv
`timescale 1ns/1ps
// Measured-domain edge counter.
// Counts measured-clock edges while the synchronised gate is open and
// the free-run enable is set. On the gate's closing edge it parks the
// count in a hold register and toggles a done flag.
// Assumes CNT_W >= 2, and that the hold register is read only after the
// toggle has crossed into the reference domain.
module fm_meas_count #(
    parameter int CNT_W = 24
) (
    input  logic             meas_clk,
    input  logic             meas_rst_n,
    input  logic             gate_i,
    input  logic             frck_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             done_tgl_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             gate_s;
    logic             frck_s;
    logic             gate_d;
    logic [CNT_W-1:0] cnt;

    fm_sync u_gate_sync (.clk(meas_clk), .rst_n(meas_rst_n), .d(gate_i), .q(gate_s));
    fm_sync u_frck_sync (.clk(meas_clk), .rst_n(meas_rst_n), .d(frck_i), .q(frck_s));

    // Count gated edges with saturation; park the count and toggle done at gate close.
    always_ff @(posedge meas_clk) begin
        if (!meas_rst_n) begin
            gate_d     <= 1'b0;
            cnt        <= '0;
            hold_o     <= '0;
            done_tgl_o <= 1'b0;
        end else begin
            gate_d <= gate_s;
            if (gate_s && !gate_d) begin
                cnt <= {{(CNT_W-1){1'b0}}, frck_s};
            end else if (gate_s && frck_s && (cnt != CNT_MAX)) begin
                cnt <= cnt + 1'b1;
            end
            if (!gate_s && gate_d) begin
                hold_o     <= cnt;
                done_tgl_o <= ~done_tgl_o;
            end
        end
    end
endmodule

// File: rtl/fm_ref_ctrl.sv
`timescale 1ns/1ps
// Reference-domain window sequencer.
// On a start pulse it opens the gate for win_len_i cycles. It then waits
// for the done toggle from the measured domain, or for a timeout, and
// captures the result and sets valid. Dropping enable_i aborts and clears valid.
// Assumes the hold register is stable whenever the done toggle changes.
module fm_ref_ctrl
    import fm_pkg::*;
#(
    parameter int WIN_W   = 24,
    parameter int CNT_W   = 24,
    parameter int TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             enable_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic             done_tgl_i,
    input  logic [CNT_W-1:0] hold_i,
    output logic             gate_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] result_o
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
    localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);

    fm_state_t        state;
    logic [WIN_W-1:0] win_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             done_s;
    logic             done_q;
    logic             done_edge;

    fm_sync u_done_sync (.clk(clk), .rst_n(rst_n), .d(done_tgl_i), .q(done_s));

    assign done_edge = done_s ^ done_q;

    // Sequence the window, the drain wait and the result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            win_cnt  <= '0;
            tmo_cnt  <= '0;
            gate_o   <= 1'b0;
            valid_o  <= 1'b0;
            result_o <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= done_s;
            if (!enable_i) begin
                state   <= ST_IDLE;
                gate_o  <= 1'b0;
                valid_o <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start_i) begin
                            if (win_len_i == '0) begin
                                result_o <= '0;
                                valid_o  <= 1'b1;
                                state    <= ST_DONE;
                            end else begin
                                win_cnt <= win_len_i;
                                gate_o  <= 1'b1;
                                state   <= ST_WINDOW;
                            end
                        end
                    end
                    ST_WINDOW: begin
                        if (win_cnt == WIN_ONE) begin
                            gate_o  <= 1'b0;
                            tmo_cnt <= '0;
                            state   <= ST_DRAIN;
                        end else begin
                            win_cnt <= win_cnt - 1'b1;
                        end
                    end
                    ST_DRAIN: begin
                        if (done_edge) begin
                            result_o <= hold_i;
                            valid_o  <= 1'b1;
                            state    <= ST_DONE;
                        end else if (tmo_cnt == TMO_LAST) begin
                            result_o <= '0;
                            valid_o  <= 1'b1;
                            state    <= ST_DONE;
                        end else begin
                            tmo_cnt <= tmo_cnt + 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
// Gated-window frequency meter top.
// Holds the control and monitor registers in the reference domain, detects
// the start edge of the meter enable, and wires the reference sequencer to
// the measured-domain counter. Reads are combinational on bus_addr.
// Assumes DATA_W > WIN_W, DATA_W > FRCK_POS and DATA_W >= CNT_W.
module freq_meter
    import fm_pkg::*;
#(
    parameter int WIN_W   = 24,
    parameter int CNT_W   = 24,
    parameter int TMO_CYC = 64,
    parameter int DATA_W  = 32
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              meas_clk,
    input  logic              meas_rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int EN_POS = WIN_W;

    logic [WIN_W-1:0] win_len;
    logic             meter_en;
    logic             meter_en_q;
    logic             frck_en;
    logic             start_pulse;
    logic             gate_ref;
    logic             meas_valid;
    logic [CNT_W-1:0] result_cnt;
    logic [CNT_W-1:0] hold_cnt;
    logic             done_tgl;

    // Register writes; the result and valid words are read-only.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            win_len    <= '0;
            meter_en   <= 1'b0;
            meter_en_q <= 1'b0;
            frck_en    <= 1'b0;
        end else begin
            meter_en_q <= meter_en;
            if (bus_wr && bus_addr == ADDR_CTRL) begin
                win_len  <= bus_wdata[WIN_W-1:0];
                meter_en <= bus_wdata[EN_POS];
            end
            if (bus_wr && bus_addr == ADDR_MON) begin
                frck_en <= bus_wdata[FRCK_POS];
            end
        end
    end

    assign start_pulse = meter_en & ~meter_en_q;

    // Read multiplexer with unused bits tied to zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[WIN_W-1:0] = win_len;
                bus_rdata[EN_POS]    = meter_en;
            end
            ADDR_MON: begin
                bus_rdata[FRCK_POS]  = frck_en;
                bus_rdata[VALID_POS] = meas_valid;
            end
            ADDR_RES: begin
                bus_rdata[CNT_W-1:0] = result_cnt;
            end
            default: begin
            end
        endcase
    end

    fm_ref_ctrl #(
        .WIN_W  (WIN_W),
        .CNT_W  (CNT_W),
        .TMO_CYC(TMO_CYC)
    ) u_ref_ctrl (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .start_i   (start_pulse),
        .enable_i  (meter_en),
        .win_len_i (win_len),
        .done_tgl_i(done_tgl),
        .hold_i    (hold_cnt),
        .gate_o    (gate_ref),
        .valid_o   (meas_valid),
        .result_o  (result_cnt)
    );

    fm_meas_count #(
        .CNT_W(CNT_W)
    ) u_meas_count (
        .meas_clk  (meas_clk),
        .meas_rst_n(meas_rst_n),
        .gate_i    (gate_ref),
        .frck_i    (frck_en),
        .hold_o    (hold_cnt),
        .done_tgl_o(done_tgl)
    );
endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
// Checker for the reference-domain behaviour of freq_meter, bound to the top.
module fm_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meter_en,
    input logic             valid,
    input logic             gate,
    input logic [CNT_W-1:0] result
);
    // R5
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meter_en |=> !valid);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> $stable(result));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(meter_en));

    // R3
    gate_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate && valid));

    // R3
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (!$past(valid) && $past(meter_en)));
endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W)) u_fm_checker (
    .clk     (ref_clk),
    .rst_n   (ref_rst_n),
    .meter_en(meter_en),
    .valid   (meas_valid),
    .gate    (gate_ref),
    .result  (result_cnt)
);

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
// Directed bench for freq_meter: one task per scenario, each checking itself.
module test_freq_meter;
    localparam int CNT_W = 12;
    localparam int DW    = 32;

    logic          ref_clk = 1'b0;
    logic          meas_clk = 1'b0;
    logic          ref_rst_n = 1'b0;
    logic          meas_rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;

    realtime meas_half = 3.75;
    bit      meas_run = 1'b1;
    int      checks = 0;
    int      errors = 0;
    bit      finished = 1'b0;

    freq_meter #(.CNT_W(CNT_W)) i_freq_meter (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .meas_clk  (meas_clk),
        .meas_rst_n(meas_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #2.5 ref_clk = ~ref_clk;

    always begin
        if (meas_run) #(meas_half) meas_clk = ~meas_clk;
        else #1;
    end

    task automatic check_eq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input logic [DW-1:0] act, input int lo, input int hi);
        checks++;
        if (int'(act) < lo || int'(act) > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge ref_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge ref_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge ref_clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Clear, start with a window, poll valid, return the result.
    task automatic measure(input int win, output logic [DW-1:0] res, output bit got);
        logic [DW-1:0] m;
        wr(2'd0, 32'd0);
        wr(2'd0, (32'd1 << 24) | DW'(win));
        got = 1'b0;
        for (int i = 0; i < 20000 && !got; i++) begin
            rd(2'd1, m);
            got = m[0];
        end
        rd(2'd2, res);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(2'd0, v); check_eq("R1 ctrl", v, 0);
        rd(2'd1, v); check_eq("R1 mon", v, 0);
        rd(2'd2, v); check_eq("R1 result", v, 0);
    endtask

    task automatic t_layout();
        logic [DW-1:0] v;
        wr(2'd0, 32'hFF12_3456);
        rd(2'd0, v); check_eq("R2 ctrl readback", v, 32'h0112_3456);
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'hFFFF_FFFE);
        rd(2'd1, v); check_eq("R2 mon readback", v, 32'h0000_0100);
        rd(2'd3, v); check_eq("R2 addr3", v, 0);
    endtask

    task automatic t_ratio(input realtime half, input int win, input int lo, input int hi, input string tag);
        logic [DW-1:0] r; bit got;
        meas_half = half;
        measure(win, r, got);
        check_eq({tag, " valid"}, DW'(got), 1);
        check_rng({tag, " count"}, r, lo, hi);
    endtask

    task automatic t_sticky_clear();
        logic [DW-1:0] r1, r2, m;
        rd(2'd2, r1);
        repeat (100) @(negedge ref_clk);
        rd(2'd1, m); check_eq("R4 valid sticky", DW'(m[0]), 1);
        rd(2'd2, r2); check_eq("R4 result stable", r2, r1);
        wr(2'd0, 32'd0);
        rd(2'd1, m); check_eq("R5 valid cleared", DW'(m[0]), 0);
    endtask

    task automatic t_readonly();
        logic [DW-1:0] r1, r2, m;
        rd(2'd2, r1);
        wr(2'd2, 32'h0000_0055);
        rd(2'd2, r2); check_eq("R10 result write ignored", r2, r1);
        wr(2'd1, 32'h0000_0101);
        rd(2'd1, m); check_eq("R10 valid write ignored", m, 32'h0000_0100);
    endtask

    task automatic t_frck_off();
        logic [DW-1:0] r; bit got;
        wr(2'd1, 32'h0);
        measure(256, r, got);
        check_eq("R6 valid", DW'(got), 1);
        check_eq("R6 result zero", r, 0);
        wr(2'd1, 32'h100);
    endtask

    task automatic t_stopped();
        logic [DW-1:0] r; bit got;
        meas_run = 1'b0;
        #20;
        measure(16, r, got);
        check_eq("R7 valid", DW'(got), 1);
        check_eq("R7 result zero", r, 0);
        meas_run = 1'b1;
        #50;
    endtask

    task automatic t_saturate();
        logic [DW-1:0] r; bit got;
        meas_half = 2.0;
        measure(4000, r, got);
        check_eq("R8 saturated", r, 32'd4095);
    endtask

    task automatic t_zero_win();
        logic [DW-1:0] m, r;
        wr(2'd0, 32'd0);
        wr(2'd0, 32'h0100_0000);
        rd(2'd1, m); check_eq("R9 valid next edge", DW'(m[0]), 1);
        rd(2'd2, r); check_eq("R9 result zero", r, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge ref_clk);
        ref_rst_n = 1'b1;
        meas_rst_n = 1'b1;
        t_reset();
        t_layout();
        wr(2'd1, 32'h100);
        t_ratio(3.75, 1024, 680, 686, "R3 slow");
        t_ratio(2.0, 1024, 1277, 1283, "R3 fast");
        t_sticky_clear();
        t_readonly();
        t_ratio(5.0, 512, 253, 259, "R11 remeasure");
        t_frck_off();
        t_stopped();
        t_saturate();
        t_zero_win();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule